// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block serves a single CPU interface of an interrupt controller. It handles the two CPU operations that change interrupt state. The first is the acknowledge read, which takes the highest-priority pending interrupt chosen by an external selector and returns its ID. The second is the end-of-interrupt (EOI) write, which retires the most urgent active priority level. The block does not store the per-interrupt pending, active or configuration bits. Those stay in an external register file. The block drives single-cycle pulses that tell the register file what to set or clear, and it reads back the few per-interrupt fields it needs on its inputs.

Internally the block holds two things. One is a set of active-priority bits with one bit per preemption level. The other is the running priority, which is derived from those bits. A preemption level is the group priority shifted right by the binary point plus one. An interrupt can be acknowledged only if its raw priority is strictly more urgent, meaning numerically lower, than the running priority. Software-generated interrupts (IDs below 16) may be raised by several source CPUs at once. They are acknowledged one source at a time, and the number of the chosen source is reported in the upper bits of the returned value.

Top module: `iaeu_core`

## Requirements
- R1: When `ack_req` is seen while `pend_id` is 1023, the next cycle shows `ack_valid`=1 with `ack_data`=1023. No pend_clr, act_set or sgi_src_clr pulse is produced, and `run_prio` is unchanged.
- R2: When the pending interrupt's 8-bit priority is greater than or equal to `run_prio`, an acknowledge returns 1023 and changes no state.
- R3: An accepted acknowledge of an ID of 16 or more returns the ID in `ack_data[9:0]` with bits 12:10 zero. It also pulses `pend_clr` and `act_set`.
- R4: An accepted acknowledge of an ID below 16 selects the lowest set bit of `pend_src`. It pulses `sgi_src_clr` with that bit alone and returns the source number in `ack_data[12:10]` and the ID in `ack_data[9:0]`.
- R5: For an ID below 16, `pend_clr` pulses only if `pend_src` has no set bit left once the selected bit is removed.
- R6: The group priority is the priority ANDed with 0xFF shifted left by `bin_point`+1. After an accepted acknowledge, `run_prio` equals that group priority.
- R7: An EOI that is not ignored pulses `act_clr` with `done_id` equal to `eoi_id`, and clears the lowest-numbered set active-priority level. `run_prio` then becomes the next set level shifted left by `bin_point`+1, or 0x100 if no level remains.
- R8: An EOI with `eoi_nonsec`=1 for a group-0 interrupt (`eoi_grp1`=0) is ignored. There is no `act_clr` pulse and `run_prio` is unchanged.
- R9: On any EOI, `rearm_pend` pulses when `legacy_mode`, `eoi_level_cfg`, `eoi_enabled`, `eoi_line` and `eoi_targeted` are all 1. It does not pulse otherwise.
- R10: Every result appears on the clock edge that samples its strobe. All pulses last one cycle. Reset gives `run_prio`=0x100 with every pulse and `ack_valid` at 0.
- R11: When an acknowledge and an EOI arrive in the same cycle, the acknowledge is judged against the running priority from before that EOI. Both take effect. If the acknowledge is accepted, `run_prio` becomes its group priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Acknowledge read strobe |
| pend_id | input | 10 | Current highest pending ID from the selector (1023 = none) |
| pend_prio | input | 8 | Priority of `pend_id` |
| pend_src | input | NCPU | Source-CPU mask of `pend_id` when it is below 16 |
| bin_point | input | 3 | Binary point |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID being completed |
| eoi_nonsec | input | 1 | EOI comes from a non-secure access |
| eoi_grp1 | input | 1 | Completed interrupt belongs to group 1 |
| legacy_mode | input | 1 | Legacy revision behaviour enabled |
| eoi_level_cfg | input | 1 | Completed interrupt is level-sensitive |
| eoi_enabled | input | 1 | Completed interrupt is enabled |
| eoi_line | input | 1 | Completed interrupt's input line is high |
| eoi_targeted | input | 1 | Completed interrupt targets this CPU |
| ack_valid | output | 1 | Acknowledge data valid pulse |
| ack_data | output | 13 | Returned value: source number [12:10], ID [9:0] |
| pend_clr | output | 1 | Clear pending pulse for the acknowledged ID |
| act_set | output | 1 | Set active pulse for the acknowledged ID |
| sgi_src_clr | output | NCPU | One-hot source bit to drop from the SGI source mask |
| act_clr | output | 1 | Clear active pulse for `done_id` |
| rearm_pend | output | 1 | Set pending pulse for `done_id` |
| done_id | output | 10 | ID of the last EOI |
| run_prio | output | 9 | Running priority (0x100 = idle) |

## Verification
An acknowledge and an EOI can fall in the same cycle. The two then compete for the same active-priority register and running priority. The bench provokes this collision when the running priority is 0x50. It raises both strobes in one cycle, with a pending priority of 0x4F and a completion that retires level 10. The check is that the acknowledge is accepted against the old priority, that act_set, pend_clr and act_clr all pulse in that one cycle, and that `run_prio` settles at 0x48. A later EOI must then return it to 0x100, which proves the retired level was really removed.

// File: rtl/iaeu_pkg.sv
package iaeu_pkg;
    localparam int ID_W        = 10;
    localparam int PRIO_W      = 8;
    localparam int BPR_W       = 3;
    localparam int SPURIOUS_ID = 1023;
    localparam int LVL_W       = PRIO_W - 1;
    localparam int LVL_N       = 1 << LVL_W;
endpackage

// File: rtl/iaeu_grp_prio.sv
module iaeu_grp_prio
    import iaeu_pkg::*;
(
    input  logic [PRIO_W-1:0] prio,
    input  logic [BPR_W-1:0]  bpr,
    output logic [BPR_W:0]    shamt,
    output logic [PRIO_W-1:0] gprio,
    output logic [LVL_W-1:0]  level
);
    logic [PRIO_W-1:0] mask;
    logic [PRIO_W-1:0] lvl_full;

    always_comb begin
        shamt    = {1'b0, bpr} + 1'b1;
        mask     = {PRIO_W{1'b1}} << shamt;
        gprio    = prio & mask;
        lvl_full = gprio >> shamt;
        level    = lvl_full[LVL_W-1:0];
    end
endmodule

// File: rtl/iaeu_ffs.sv
module iaeu_ffs #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        onehot = vec & (~vec + W'(1));
    end
endmodule

// File: rtl/iaeu_core.sv
module iaeu_core
    import iaeu_pkg::*;
#(
    parameter int NCPU      = 8,
    parameter int SGI_COUNT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ack_req,
    input  logic [ID_W-1:0]           pend_id,
    input  logic [PRIO_W-1:0]         pend_prio,
    input  logic [NCPU-1:0]           pend_src,
    input  logic [BPR_W-1:0]          bin_point,
    input  logic                      eoi_req,
    input  logic [ID_W-1:0]           eoi_id,
    input  logic                      eoi_nonsec,
    input  logic                      eoi_grp1,
    input  logic                      legacy_mode,
    input  logic                      eoi_level_cfg,
    input  logic                      eoi_enabled,
    input  logic                      eoi_line,
    input  logic                      eoi_targeted,
    output logic                      ack_valid,
    output logic [ID_W+$clog2(NCPU)-1:0] ack_data,
    output logic                      pend_clr,
    output logic                      act_set,
    output logic [NCPU-1:0]           sgi_src_clr,
    output logic                      act_clr,
    output logic                      rearm_pend,
    output logic [ID_W-1:0]           done_id,
    output logic [PRIO_W:0]           run_prio
);
    localparam int SRC_W = $clog2(NCPU);
    localparam int ACK_W = ID_W + SRC_W;
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    typedef struct packed {
        logic              ack_valid;
        logic [ACK_W-1:0]  ack_data;
        logic              pend_clr;
        logic              act_set;
        logic [NCPU-1:0]   src_clr;
        logic              act_clr;
        logic              rearm;
        logic [ID_W-1:0]   done_id;
        logic [LVL_N-1:0]  apr;
        logic [PRIO_W:0]   run;
    } st_t;

    st_t s_d, s_q;

    // group priority and preemption level of the pending interrupt
    logic [BPR_W:0]    bp_shamt;
    logic [PRIO_W-1:0] grp_prio;
    logic [LVL_W-1:0]  grp_level;

    iaeu_grp_prio u_grp (
        .prio  (pend_prio),
        .bpr   (bin_point),
        .shamt (bp_shamt),
        .gprio (grp_prio),
        .level (grp_level)
    );

    // most urgent active level
    logic              apr_found;
    logic [LVL_W-1:0]  apr_idx;
    logic [LVL_N-1:0]  apr_low_oh;

    iaeu_ffs #(.W(LVL_N), .IW(LVL_W)) u_apr_low (
        .vec    (s_q.apr),
        .found  (apr_found),
        .idx    (apr_idx),
        .onehot (apr_low_oh)
    );

    // next level after the most urgent is retired
    logic [LVL_N-1:0]  apr_after;
    logic              nxt_found;
    logic [LVL_W-1:0]  nxt_idx;
    logic [LVL_N-1:0]  nxt_oh;

    assign apr_after = s_q.apr & ~apr_low_oh;

    iaeu_ffs #(.W(LVL_N), .IW(LVL_W)) u_apr_next (
        .vec    (apr_after),
        .found  (nxt_found),
        .idx    (nxt_idx),
        .onehot (nxt_oh)
    );

    // lowest source CPU of a software-generated interrupt
    logic              src_found;
    logic [SRC_W-1:0]  src_idx;
    logic [NCPU-1:0]   src_oh;

    iaeu_ffs #(.W(NCPU), .IW(SRC_W)) u_src (
        .vec    (pend_src),
        .found  (src_found),
        .idx    (src_idx),
        .onehot (src_oh)
    );

    logic [PRIO_W-1:0] rest_prio;
    logic [LVL_N-1:0]  apr_mid;
    logic [PRIO_W:0]   run_mid;
    logic              eoi_ignored;
    logic              ack_ok;
    logic              is_sgi;

    always_comb begin
        s_d           = s_q;
        s_d.ack_valid = 1'b0;
        s_d.pend_clr  = 1'b0;
        s_d.act_set   = 1'b0;
        s_d.src_clr   = '0;
        s_d.act_clr   = 1'b0;
        s_d.rearm     = 1'b0;

        rest_prio   = PRIO_W'(nxt_idx) << bp_shamt;
        eoi_ignored = eoi_nonsec && !eoi_grp1;
        apr_mid     = s_q.apr;
        run_mid     = s_q.run;

        // completion first: priority drop
        if (eoi_req) begin
            s_d.done_id = eoi_id;
            s_d.rearm   = legacy_mode && eoi_level_cfg && eoi_enabled
                          && eoi_line && eoi_targeted;
            if (!eoi_ignored) begin
                s_d.act_clr = 1'b1;
                if (apr_found) begin
                    apr_mid = apr_after;
                    run_mid = nxt_found ? {1'b0, rest_prio} : IDLE_PRIO;
                end
            end
        end
        s_d.apr = apr_mid;
        s_d.run = run_mid;

        // acknowledge, judged against the priority before this cycle's EOI
        ack_ok = (pend_id != ID_W'(SPURIOUS_ID)) && ({1'b0, pend_prio} < s_q.run);
        is_sgi = pend_id < ID_W'(SGI_COUNT);
        if (ack_req) begin
            s_d.ack_valid = 1'b1;
            s_d.ack_data  = ACK_W'(SPURIOUS_ID);
            if (ack_ok) begin
                s_d.act_set = 1'b1;
                s_d.apr     = apr_mid | (LVL_N'(1) << grp_level);
                s_d.run     = {1'b0, grp_prio};
                if (is_sgi) begin
                    s_d.ack_data = {src_idx, pend_id};
                    s_d.src_clr  = src_oh;
                    s_d.pend_clr = ((pend_src & ~src_oh) == '0) || !src_found;
                end else begin
                    s_d.ack_data = {{SRC_W{1'b0}}, pend_id};
                    s_d.pend_clr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.run <= IDLE_PRIO;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_valid   = s_q.ack_valid;
    assign ack_data    = s_q.ack_data;
    assign pend_clr    = s_q.pend_clr;
    assign act_set     = s_q.act_set;
    assign sgi_src_clr = s_q.src_clr;
    assign act_clr     = s_q.act_clr;
    assign rearm_pend  = s_q.rearm;
    assign done_id     = s_q.done_id;
    assign run_prio    = s_q.run;
endmodule

// File: rtl/iaeu_core_chk.sv
module iaeu_core_chk #(
    parameter int NCPU      = 8,
    parameter int SGI_COUNT = 16,
    parameter int ID_W      = 10,
    parameter int ACK_W     = 13,
    parameter int PRIO_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_req,
    input logic              eoi_req,
    input logic              ack_valid,
    input logic [ACK_W-1:0]  ack_data,
    input logic              pend_clr,
    input logic              act_set,
    input logic [NCPU-1:0]   sgi_src_clr,
    input logic              act_clr,
    input logic [PRIO_W:0]   run_prio
);
    logic [ID_W-1:0] rid;
    assign rid = ack_data[ID_W-1:0];

    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && rid == ID_W'(1023)) |-> (!act_set && !pend_clr && sgi_src_clr == '0)); // R1
    AST_ACK_LOWERS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        act_set |-> (run_prio < $past(run_prio))); // R2
    AST_PERIPH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_set && rid >= ID_W'(SGI_COUNT)) |-> (pend_clr && sgi_src_clr == '0)); // R3
    AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sgi_src_clr)); // R4
    AST_SRC_NEEDS_SGI: assert property (@(posedge clk) disable iff (!rst_n)
        (sgi_src_clr != '0) |-> (act_set && rid < ID_W'(SGI_COUNT))); // R4
    AST_RUN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_prio <= {1'b1, {PRIO_W{1'b0}}}); // R7
    AST_EOI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        act_clr |-> $past(eoi_req)); // R10
    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack_req)); // R10
    AST_SET_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        act_set |-> ack_valid); // R10
endmodule

bind iaeu_core iaeu_core_chk #(
    .NCPU      (NCPU),
    .SGI_COUNT (SGI_COUNT),
    .ID_W      (iaeu_pkg::ID_W),
    .ACK_W     (iaeu_pkg::ID_W + $clog2(NCPU)),
    .PRIO_W    (iaeu_pkg::PRIO_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_req     (ack_req),
    .eoi_req     (eoi_req),
    .ack_valid   (ack_valid),
    .ack_data    (ack_data),
    .pend_clr    (pend_clr),
    .act_set     (act_set),
    .sgi_src_clr (sgi_src_clr),
    .act_clr     (act_clr),
    .run_prio    (run_prio)
);

// File: tb/iaeu_core_tb_top.sv
module iaeu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_req = 1'b0;
    logic [9:0]  pend_id = '0;
    logic [7:0]  pend_prio = '0;
    logic [7:0]  pend_src = '0;
    logic [2:0]  bin_point = 3'd2;
    logic        eoi_req = 1'b0;
    logic [9:0]  eoi_id = '0;
    logic        eoi_nonsec = 1'b0;
    logic        eoi_grp1 = 1'b0;
    logic        legacy_mode = 1'b0;
    logic        eoi_level_cfg = 1'b0;
    logic        eoi_enabled = 1'b0;
    logic        eoi_line = 1'b0;
    logic        eoi_targeted = 1'b0;
    logic        ack_valid;
    logic [12:0] ack_data;
    logic        pend_clr;
    logic        act_set;
    logic [7:0]  sgi_src_clr;
    logic        act_clr;
    logic        rearm_pend;
    logic [9:0]  done_id;
    logic [8:0]  run_prio;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iaeu_core dut_i (.*);

    typedef struct packed {
        logic        ack;
        logic        eoi;
        logic [9:0]  pid;
        logic [7:0]  pprio;
        logic [7:0]  smask;
        logic [9:0]  eid;
        logic        ens;
        logic        egrp1;
        logic [4:0]  ecfg;   // legacy, level, enabled, line, targeted
        logic        x_ackv;
        logic [12:0] x_ack;
        logic        x_pclr;
        logic        x_aset;
        logic [7:0]  x_src;
        logic        x_aclr;
        logic        x_rearm;
        logic [8:0]  x_run;
        logic [7:0]  req;
    } vec_t;

    // binary point 2 throughout: group mask 0xF8, level = gprio >> 3
    localparam vec_t TBL [14] = '{
        '{1'b1,1'b0,10'd1023,8'h00,8'h00,10'd0, 1'b0,1'b0,5'b00000, 1'b1,13'd1023,1'b0,1'b0,8'h00,1'b0,1'b0,9'h100, 8'd1},  // R1
        '{1'b1,1'b0,10'd40,  8'h55,8'h00,10'd0, 1'b0,1'b0,5'b00000, 1'b1,13'd40,  1'b1,1'b1,8'h00,1'b0,1'b0,9'h050, 8'd3},  // R3
        '{1'b1,1'b0,10'd41,  8'h50,8'h00,10'd0, 1'b0,1'b0,5'b00000, 1'b1,13'd1023,1'b0,1'b0,8'h00,1'b0,1'b0,9'h050, 8'd2},  // R2
        '{1'b1,1'b0,10'd3,   8'h20,8'h2C,10'd0, 1'b0,1'b0,5'b00000, 1'b1,13'h0803,1'b0,1'b1,8'h04,1'b0,1'b0,9'h020, 8'd5},  // R5
        '{1'b1,1'b0,10'd3,   8'h10,8'h80,10'd0, 1'b0,1'b0,5'b00000, 1'b1,13'h1C03,1'b1,1'b1,8'h80,1'b0,1'b0,9'h010, 8'd4},  // R4
        '{1'b0,1'b1,10'd0,   8'h00,8'h00,10'd3, 1'b0,1'b0,5'b00000, 1'b0,13'd0,   1'b0,1'b0,8'h00,1'b1,1'b0,9'h020, 8'd7},  // R7
        '{1'b0,1'b1,10'd0,   8'h00,8'h00,10'd3, 1'b1,1'b0,5'b00000, 1'b0,13'd0,   1'b0,1'b0,8'h00,1'b0,1'b0,9'h020, 8'd8},  // R8
        '{1'b0,1'b1,10'd0,   8'h00,8'h00,10'd40,1'b1,1'b1,5'b00000, 1'b0,13'd0,   1'b0,1'b0,8'h00,1'b1,1'b0,9'h050, 8'd7},  // R7
        '{1'b1,1'b1,10'd50,  8'h4F,8'h00,10'd40,1'b0,1'b0,5'b00000, 1'b1,13'd50,  1'b1,1'b1,8'h00,1'b1,1'b0,9'h048, 8'd11}, // R11
        '{1'b0,1'b1,10'd0,   8'h00,8'h00,10'd50,1'b0,1'b0,5'b11111, 1'b0,13'd0,   1'b0,1'b0,8'h00,1'b1,1'b1,9'h100, 8'd9},  // R9
        '{1'b0,1'b1,10'd0,   8'h00,8'h00,10'd50,1'b0,1'b0,5'b11101, 1'b0,13'd0,   1'b0,1'b0,8'h00,1'b1,1'b0,9'h100, 8'd9},  // R9
        '{1'b0,1'b1,10'd0,   8'h00,8'h00,10'd51,1'b0,1'b0,5'b01111, 1'b0,13'd0,   1'b0,1'b0,8'h00,1'b1,1'b0,9'h100, 8'd9},  // R9
        '{1'b0,1'b0,10'd0,   8'h00,8'h00,10'd0, 1'b0,1'b0,5'b00000, 1'b0,13'd0,   1'b0,1'b0,8'h00,1'b0,1'b0,9'h100, 8'd10}, // R10
        '{1'b1,1'b0,10'd20,  8'hFF,8'h00,10'd0, 1'b0,1'b0,5'b00000, 1'b1,13'd20,  1'b1,1'b1,8'h00,1'b0,1'b0,9'h0F8, 8'd6}   // R6
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        ack_req = 1'b0;
        eoi_req = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        string r;
        r = $sformatf("R%0d", v.req);
        @(negedge clk);
        ack_req   = v.ack;   pend_id  = v.pid;   pend_prio = v.pprio; pend_src = v.smask;
        eoi_req   = v.eoi;   eoi_id   = v.eid;   eoi_nonsec = v.ens;  eoi_grp1 = v.egrp1;
        {legacy_mode, eoi_level_cfg, eoi_enabled, eoi_line, eoi_targeted} = v.ecfg;
        @(posedge clk);
        #1;
        chk(r, "ack_valid", 32'(ack_valid), 32'(v.x_ackv));
        if (v.x_ackv) chk(r, "ack_data", 32'(ack_data), 32'(v.x_ack));
        chk(r, "pend_clr", 32'(pend_clr), 32'(v.x_pclr));
        chk(r, "act_set", 32'(act_set), 32'(v.x_aset));
        chk(r, "sgi_src_clr", 32'(sgi_src_clr), 32'(v.x_src));
        chk(r, "act_clr", 32'(act_clr), 32'(v.x_aclr));
        if (v.x_aclr) chk(r, "done_id", 32'(done_id), 32'(v.eid));
        chk(r, "rearm_pend", 32'(rearm_pend), 32'(v.x_rearm));
        chk(r, "run_prio", 32'(run_prio), 32'(v.x_run));
    endtask

    task automatic do_reset();
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10", "reset run_prio", 32'(run_prio), 32'h100);
        chk("R10", "reset ack_valid", 32'(ack_valid), 32'h0);
        chk("R10", "reset pulses", 32'({pend_clr, act_set, act_clr, rearm_pend, |sgi_src_clr}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        bin_point = 3'd2;
        for (int i = 0; i < 14; i++) apply(TBL[i]);

        // mid-run reset clears the active level left by the last vector (R10)
        do_reset();

        // R6: binary point 0 keeps seven priority bits
        bin_point = 3'd0;
        apply('{1'b1,1'b0,10'd17,8'h33,8'h00,10'd0,1'b0,1'b0,5'b0,
                1'b1,13'd17,1'b1,1'b1,8'h00,1'b0,1'b0,9'h032,8'd6});
        // R7: retiring the only level returns to idle
        apply('{1'b0,1'b1,10'd0,8'h00,8'h00,10'd17,1'b0,1'b0,5'b0,
                1'b0,13'd0,1'b0,1'b0,8'h00,1'b1,1'b0,9'h100,8'd7});

        // R6: binary point 7 masks every priority bit to zero
        do_reset();
        bin_point = 3'd7;
        apply('{1'b1,1'b0,10'd18,8'h80,8'h00,10'd0,1'b0,1'b0,5'b0,
                1'b1,13'd18,1'b1,1'b1,8'h00,1'b0,1'b0,9'h000,8'd6});
        // R2: equal priority (0 vs 0) is refused
        apply('{1'b1,1'b0,10'd19,8'h00,8'h00,10'd0,1'b0,1'b0,5'b0,
                1'b1,13'd1023,1'b0,1'b0,8'h00,1'b0,1'b0,9'h000,8'd2});
        // R5: SGI with a single source (lowest bit 0) clears pending; refused here, so retire first
        apply('{1'b0,1'b1,10'd0,8'h00,8'h00,10'd18,1'b0,1'b0,5'b0,
                1'b0,13'd0,1'b0,1'b0,8'h00,1'b1,1'b0,9'h100,8'd7});
        apply('{1'b1,1'b0,10'd0,8'h40,8'h01,10'd0,1'b0,1'b0,5'b0,
                1'b1,13'h0000,1'b1,1'b1,8'h01,1'b0,1'b0,9'h000,8'd5});

        drive_idle();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule